// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, through two independent one-way paths. The A-to-B path carries data from bus A onto bus B, and the B-to-A path carries data from bus B onto bus A. Each path has a capture register with its own clock and a source select. The select picks either the value currently present on the opposite bus or the value held in the register. Each path also has an output enable. Data leaving either path is always the bit-wise inverse of the source that was picked.

Each bus port is split into three signals: an input, an output and an output-enable, so that the surrounding logic resolves the shared wire. The capture registers load on every rising edge of their clocks, whatever the selects and enables are set to. This lets the block take a snapshot of a bus while it is isolated, or while it is driving the other bus. Typical uses are live pass-through, replay of stored words, storing one word in both registers, and holding both buses through a reinforcing loop.

Top module: `dual_path_xcvr`

## Requirements
- R1: On every rising edge of `ab_clk` the A-to-B register loads `a_in`, and on every rising edge of `ba_clk` the B-to-A register loads `b_in`. This holds for any setting of the selects and enables.
- R2: A select at 0 makes its path use the live opposite-bus input (`a_in` for A-to-B, `b_in` for B-to-A). A select at 1 makes its path use that path's register.
- R3: `ab_drive` is active high and enables port B (`b_oe`=1). `ba_hold_n` is active low and enables port A (`a_oe`=1). A port whose enable is inactive shows `*_oe`=0 and an all-zero `*_out`.
- R4: Every enabled output equals the bitwise inverse of its picked source, for both live and stored sources.
- R5: `rst_n` low clears both registers to zero at once, without a clock edge.
- R6: With `ab_drive`=0 and `ba_hold_n`=1, neither port drives, and both registers still load on their clock edges.
- R7: With both ports enabled and both selects at 0, an input pair with `b_in` = ~`a_in` is reproduced on the outputs (`a_out`=`a_in`, `b_out`=`b_in`). Both buses therefore hold their last values with no other driver.
- R8: While A drives B live, a `ba_clk` edge stores the inverted A word now on bus B. A later stored replay onto bus A then returns the original A word.
- R9: With both ports enabled and both selects at 1, port B shows ~(A-to-B register) and port A shows ~(B-to-A register) at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| ab_clk | input | 1 | Capture clock of the A-to-B register |
| ba_clk | input | 1 | Capture clock of the B-to-A register |
| ab_sel | input | 1 | A-to-B source: 0 live bus A, 1 stored |
| ba_sel | input | 1 | B-to-A source: 0 live bus B, 1 stored |
| ab_drive | input | 1 | Active-high enable of port B output |
| ba_hold_n | input | 1 | Active-low enable of port A output |
| a_in | input | WIDTH | Resolved value of bus A |
| a_out | output | WIDTH | Value the block drives on bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | WIDTH | Resolved value of bus B |
| b_out | output | WIDTH | Value the block drives on bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The assertions are sampled on the two register clocks. They assume that bus inputs, selects and enables are steady around each rising edge of those clocks, just as the capture setup window requires. The bench changes data and controls only on falling edges of its own clock. It raises a register clock only after the resolved buses have settled, so no sampled value is caught mid-change. The bench also resolves every bus from its external driver, the block driver and a keeper. It reports any point at which both drivers are active.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  typedef struct packed {
    logic drive;
    src_e src;
  } lane_ctl_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  AST_CAPTURE_ANY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d)) else $error("capture lost"); // R1

endmodule

// File: rtl/xcvr_enable_decode.sv
`timescale 1ns/1ps
module xcvr_enable_decode
  import xcvr_pkg::*;
(
  input  logic      ab_drive,
  input  logic      ba_hold_n,
  input  logic      ab_sel,
  input  logic      ba_sel,
  output lane_ctl_t ab_ctl,
  output lane_ctl_t ba_ctl,
  output logic      isolate,
  output logic      loopback,
  output logic      dual_replay
);

  function automatic src_e pick_src(input logic s);
    return s ? SRC_HELD : SRC_LIVE;
  endfunction

  always_comb begin
    ab_ctl.drive = ab_drive;
    ab_ctl.src   = pick_src(ab_sel);
    ba_ctl.drive = ~ba_hold_n;
    ba_ctl.src   = pick_src(ba_sel);
  end

  assign isolate     = ~ab_drive & ba_hold_n;
  assign loopback    = ab_drive & ~ba_hold_n & ~ab_sel & ~ba_sel;
  assign dual_replay = ab_drive & ~ba_hold_n & ab_sel & ba_sel;

endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  lane_ctl_t    ctl,
  output logic [W-1:0] held,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);

  logic [W-1:0] picked;
  logic [W-1:0] shaped;

  xcvr_capture_reg #(.W(W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (live),
    .q    (held)
  );

  assign picked = (ctl.src == SRC_HELD) ? held : live;

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign shaped[i] = ~picked[i];
  end

  assign bus_out = ctl.drive ? shaped : '0;
  assign bus_oe  = ctl.drive;

  AST_LIVE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl.src == SRC_LIVE) |-> bus_out == ~live) else $error("live path"); // R4
  AST_HELD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ctl.src == SRC_HELD) |-> bus_out == ~held) else $error("held path"); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0) else $error("idle drive"); // R3

endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             ab_clk,
  input  logic             ba_clk,
  input  logic             ab_sel,
  input  logic             ba_sel,
  input  logic             ab_drive,
  input  logic             ba_hold_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  lane_ctl_t        ab_ctl, ba_ctl;
  logic             isolate, loopback, dual_replay;
  logic [WIDTH-1:0] ab_held, ba_held;

  xcvr_enable_decode u_dec (
    .ab_drive   (ab_drive),
    .ba_hold_n  (ba_hold_n),
    .ab_sel     (ab_sel),
    .ba_sel     (ba_sel),
    .ab_ctl     (ab_ctl),
    .ba_ctl     (ba_ctl),
    .isolate    (isolate),
    .loopback   (loopback),
    .dual_replay(dual_replay)
  );

  xcvr_lane #(.W(WIDTH)) u_ab (
    .clk    (ab_clk),
    .rst_n  (rst_n),
    .live   (a_in),
    .ctl    (ab_ctl),
    .held   (ab_held),
    .bus_out(b_out),
    .bus_oe (b_oe)
  );

  xcvr_lane #(.W(WIDTH)) u_ba (
    .clk    (ba_clk),
    .rst_n  (rst_n),
    .live   (b_in),
    .ctl    (ba_ctl),
    .held   (ba_held),
    .bus_out(a_out),
    .bus_oe (a_oe)
  );

  AST_ISOLATE_SILENT: assert property (@(posedge ab_clk) disable iff (!rst_n)
    isolate |-> (!a_oe && !b_oe)) else $error("isolation drives"); // R6
  AST_LOOP_REINFORCE: assert property (@(posedge ab_clk) disable iff (!rst_n)
    (loopback && b_in == ~a_in) |-> (a_out == a_in && b_out == b_in)) else $error("loop"); // R7
  AST_DUAL_REPLAY: assert property (@(posedge ba_clk) disable iff (!rst_n)
    dual_replay |-> (a_out == ~ba_held && b_out == ~ab_held)) else $error("replay"); // R9
  AST_ENABLE_POLARITY: assert property (@(posedge ba_clk) disable iff (!rst_n)
    (b_oe == ab_drive) && (a_oe == !ba_hold_n)) else $error("polarity"); // R3

endmodule

// File: tb/sim_dual_path_xcvr.sv
`timescale 1ns/1ps
module sim_dual_path_xcvr;

  logic       clk = 1'b0;
  logic       rst_n, ab_clk, ba_clk, ab_sel, ba_sel, ab_drive, ba_hold_n;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_oe, b_oe;
  logic [7:0] ext_a, ext_b, ref_ab, ref_ba;
  logic       ext_a_en, ext_b_en;
  int         checks = 0, errors = 0, cyc = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dual_path_xcvr #(.WIDTH(8)) u0 (
    .rst_n(rst_n), .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_sel(ab_sel), .ba_sel(ba_sel),
    .ab_drive(ab_drive), .ba_hold_n(ba_hold_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // bus resolution: external driver, else block driver, else keeper
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #0.1;
      if (ext_a_en && a_oe) begin errors++; $display("FAIL R3 contention on A actual=%b expected=0", a_oe); end
      if (ext_b_en && b_oe) begin errors++; $display("FAIL R3 contention on B actual=%b expected=0", b_oe); end
      a_in = ext_a_en ? ext_a : (a_oe ? a_out : a_in);
      b_in = ext_b_en ? ext_b : (b_oe ? b_out : b_in);
    end
  endtask

  task automatic apply(input logic d_ab, input logic h_ba_n, input logic s_ab, input logic s_ba);
    @(negedge clk);
    ab_drive = d_ab; ba_hold_n = h_ba_n; ab_sel = s_ab; ba_sel = s_ba;
    ext_a_en = h_ba_n; ext_b_en = ~d_ab;
    settle();
  endtask

  task automatic pulse_ab();
    @(negedge clk); ref_ab = a_in; ab_clk = 1'b1;
    @(negedge clk); ab_clk = 1'b0; settle();
  endtask

  task automatic pulse_ba();
    @(negedge clk); ref_ba = b_in; ba_clk = 1'b1;
    @(negedge clk); ba_clk = 1'b0; settle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_up();
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    rst_n = 1'b0; ab_clk = 0; ba_clk = 0; ab_sel = 0; ba_sel = 0; ab_drive = 0; ba_hold_n = 1;
    ext_a = 8'h11; ext_b = 8'h22; ext_a_en = 1; ext_b_en = 1; a_in = 8'h11; b_in = 8'h22;
    ref_ab = 0; ref_ba = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state: stored replay of cleared registers gives all ones
    apply(1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 reset b_out", b_out, 8'hFF);
    check("R5 reset a_out", a_out, 8'hFF);
    // R6 isolation: no drive, registers still load
    apply(1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 isolate a_oe", {7'd0, a_oe}, 8'h00);
    check("R6 isolate b_oe", {7'd0, b_oe}, 8'h00);
    ext_a = 8'h96; ext_b = 8'h4B; settle();
    pulse_ab(); pulse_ba();
    apply(1'b1, 1'b0, 1'b1, 1'b1);
    check("R6 isolated load A", b_out, ~8'h96);
    check("R6 isolated load B", a_out, ~8'h4B);
    // R1 R2 R3 R4 sweep over every control combination and data pattern
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        ext_a = pats[p]; ext_b = {pats[p][3:0], ~pats[p][7:4]};
        apply(c[0], c[1], c[2], c[3]);
        check("R3 b_oe", {7'd0, b_oe}, {7'd0, ab_drive});
        check("R3 a_oe", {7'd0, a_oe}, {7'd0, ~ba_hold_n});
        check("R2/R4 b_out", b_out, ab_drive ? ~(ab_sel ? ref_ab : a_in) : 8'h00);
        check("R2/R4 a_out", a_out, !ba_hold_n ? ~(ba_sel ? ref_ba : b_in) : 8'h00);
        if (p[0]) pulse_ab(); else pulse_ba();
        check("R1 b_out after capture", b_out, ab_drive ? ~(ab_sel ? ref_ab : a_in) : 8'h00);
        check("R1 a_out after capture", a_out, !ba_hold_n ? ~(ba_sel ? ref_ba : b_in) : 8'h00);
      end
    end
    // R7 reinforcing loop keeps both buses
    ext_a = 8'h5A; ext_b = 8'hA5; apply(1'b0, 1'b1, 1'b0, 1'b0);
    apply(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk); settle();
    check("R7 loop a_out", a_out, 8'h5A);
    check("R7 loop b_out", b_out, 8'hA5);
    check("R7 loop a bus", a_in, 8'h5A);
    // R8 A word stored in both registers
    ext_a = 8'h3C; apply(1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 live onto B", b_in, 8'hC3);
    pulse_ab(); pulse_ba();
    apply(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 replay onto A", a_out, 8'h3C);
    apply(1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 replay onto B", b_out, 8'hC3);
    // R9 simultaneous replay both ways
    ext_a = 8'h12; ext_b = 8'hE7; apply(1'b0, 1'b1, 1'b0, 1'b0);
    pulse_ab(); pulse_ba();
    apply(1'b1, 1'b0, 1'b1, 1'b1);
    check("R9 dual b_out", b_out, 8'hED);
    check("R9 dual a_out", a_out, 8'h18);
    // R5 asynchronous clear mid-operation, no clock edge
    @(negedge clk); rst_n = 1'b0; #0.5; settle();
    check("R5 async clear b_out", b_out, 8'hFF);
    check("R5 async clear a_out", a_out, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    finish_up();
  end

endmodule